// File: doc/BRIEF.md
# Dynamic Priority Interrupt Resolver

This block picks one winning interrupt line out of a set of up to three banks of 32 lines. Each line arrives with its latched pending bit, its mask bit, a class routing bit (fast or normal) and a small priority value. The surrounding controller gives it these per-line vectors and pulses a request strobe. One clock later the block returns, for each of the two classes, the global number of the most urgent candidate line and a flag that says whether any line qualified at all.

Both classes are resolved side by side from the same snapshot, by two copies of the same selection logic. The comparison logic is purely combinational. Its result is captured into output registers only on the request strobe, so the selection tree stays out of the bus timing path. Between requests the outputs hold their last value.

Top module: `irq_winner_pick`

## Requirements
- R1: A line competes in a class only if its pending bit is 1, its mask bit is 0 and its routing bit equals the class (routing bit 1 selects the fast class, 0 the normal class); any other line has no effect on that class's result.
- R2: Among candidates, the line with the numerically smallest priority wins; priority 0 is the most urgent and the largest value (all ones) still beats having no candidate.
- R3: When several candidates share the best priority, the one with the highest line number wins.
- R4: The reported number is the global line index, bank index times 32 plus the bit position within the bank, so line 31 of bank 0 is 31 and line 0 of bank 1 is 32.
- R5: With no candidate in a class, that class reports number 0 and its any flag is 0.
- R6: The any flag of a class is 1 whenever at least one candidate exists, which separates a real winner at line 0 from the empty case.
- R7: Results are registered on the clock edge where the request strobe is 1; `done` is 1 for exactly the following cycle, and outputs do not change in cycles after an edge without a request.
- R8: After reset both numbers are 0, both any flags are 0 and `done` is 0.
- R9: The normal and fast results are computed from the same request independently, so each class can report its own winner in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Resolve strobe; inputs are sampled on this edge |
| pending | input | NUM_BANKS*32 | Latched pending bit per line |
| mask | input | NUM_BANKS*32 | Mask bit per line, 1 blocks the line |
| fast_route | input | NUM_BANKS*32 | Class routing bit per line, 1 = fast |
| prio_flat | input | NUM_BANKS*32*PRIO_W | Priority of line i in bits [i*PRIO_W +: PRIO_W] |
| norm_id | output | ID_W | Winning normal-class line number |
| norm_any | output | 1 | Normal class had a candidate |
| fast_id | output | ID_W | Winning fast-class line number |
| fast_any | output | 1 | Fast class had a candidate |
| done | output | 1 | One-cycle pulse marking fresh results |

## Verification
A fault in the candidate filter or the priority comparison shows at the ports in the cycle after the request that exercises it, as a wrong line number or a wrong any flag for one class only. A broken tie rule only appears when two candidates carry the same priority, and an index encoding fault only when the winner sits above line 31, so the stimulus places equal priorities and bank-boundary lines deliberately. A fault in the capture register shows as outputs that move without a request or a `done` pulse that is missing, late or too long.

// File: rtl/iwp_pkg.sv
package iwp_pkg;
  localparam int BANK_LINES = 32;
  localparam int CMP_W      = 8;
  localparam logic [CMP_W-1:0] START_WORST = 8'd255;

  function automatic int line_count(input int banks);
    return banks * BANK_LINES;
  endfunction

  function automatic int id_width(input int banks);
    return $clog2(banks * BANK_LINES);
  endfunction

  // candidate replaces current best on equal or better urgency
  function automatic logic takes_lead(input logic [CMP_W-1:0] p,
                                      input logic [CMP_W-1:0] best);
    return p <= best;
  endfunction
endpackage

// File: rtl/iwp_cand.sv
module iwp_cand #(
  parameter int  LINES = 96,
  parameter bit  FAST  = 1'b0
) (
  input  logic [LINES-1:0] pending,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] fast_route,
  output logic [LINES-1:0] cand
);
  localparam logic [LINES-1:0] ROUTE_WANT = FAST ? '1 : '0;

  always_comb begin
    cand = pending & ~mask & ~(fast_route ^ ROUTE_WANT);
  end
endmodule

// File: rtl/iwp_scan.sv
module iwp_scan
  import iwp_pkg::*;
#(
  parameter int LINES  = 96,
  parameter int PRIO_W = 6,
  parameter int ID_W   = 7
) (
  input  logic [LINES-1:0]        cand,
  input  logic [LINES*PRIO_W-1:0] prio_flat,
  output logic [ID_W-1:0]         win_id,
  output logic                    win_any
);
  logic [CMP_W-1:0] best;

  always_comb begin
    best    = START_WORST;
    win_id  = '0;
    win_any = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (cand[i] && takes_lead(CMP_W'(prio_flat[i*PRIO_W +: PRIO_W]), best)) begin
        best    = CMP_W'(prio_flat[i*PRIO_W +: PRIO_W]);
        win_id  = ID_W'(i);
        win_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_winner_pick.sv
module irq_winner_pick
  import iwp_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6,
  localparam int LINES    = NUM_BANKS * BANK_LINES,
  localparam int ID_W     = $clog2(NUM_BANKS * BANK_LINES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic [LINES-1:0]        pending,
  input  logic [LINES-1:0]        mask,
  input  logic [LINES-1:0]        fast_route,
  input  logic [LINES*PRIO_W-1:0] prio_flat,
  output logic [ID_W-1:0]         norm_id,
  output logic                    norm_any,
  output logic [ID_W-1:0]         fast_id,
  output logic                    fast_any,
  output logic                    done
);
  // index 0 = normal class, index 1 = fast class
  logic [LINES-1:0] cand_w  [2];
  logic [ID_W-1:0]  next_id [2];
  logic             next_any[2];
  logic [ID_W-1:0]  id_q    [2];
  logic             any_q   [2];
  logic             capture;

  assign capture = req;

  for (genvar c = 0; c < 2; c++) begin : g_class
    iwp_cand #(.LINES(LINES), .FAST(c == 1)) u_cand (
      .pending    (pending),
      .mask       (mask),
      .fast_route (fast_route),
      .cand       (cand_w[c])
    );
    iwp_scan #(.LINES(LINES), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_scan (
      .cand      (cand_w[c]),
      .prio_flat (prio_flat),
      .win_id    (next_id[c]),
      .win_any   (next_any[c])
    );
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q[c]  <= '0;
        any_q[c] <= 1'b0;
      end else if (capture) begin
        id_q[c]  <= next_id[c];
        any_q[c] <= next_any[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= capture;
  end

  assign norm_id  = id_q[0];
  assign norm_any = any_q[0];
  assign fast_id  = id_q[1];
  assign fast_any = any_q[1];
endmodule

// File: rtl/irq_winner_pick_chk.sv
module irq_winner_pick_chk #(
  parameter int LINES = 96,
  parameter int ID_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic [LINES-1:0] pending,
  input logic [LINES-1:0] mask,
  input logic [LINES-1:0] fast_route,
  input logic [ID_W-1:0]  norm_id,
  input logic             norm_any,
  input logic [ID_W-1:0]  fast_id,
  input logic             fast_any,
  input logic             done
);
  logic [LINES-1:0] snap_n, snap_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_n <= '0;
      snap_f <= '0;
    end else if (req) begin
      snap_n <= pending & ~mask & ~fast_route;
      snap_f <= pending & ~mask & fast_route;
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> done);
  assert_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !done);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(norm_id) && $stable(norm_any) && $stable(fast_id) && $stable(fast_any)));
  assert_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !norm_any) |-> norm_id == '0);
  assert_empty_zero_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fast_any) |-> fast_id == '0);
  assert_winner_is_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && norm_any) |-> snap_n[norm_id]);
  assert_winner_is_cand_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fast_any) |-> snap_f[fast_id]);
  assert_any_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (norm_any == (snap_n != '0)) && (fast_any == (snap_f != '0)));
endmodule

bind irq_winner_pick irq_winner_pick_chk #(.LINES(LINES), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .pending    (pending),
  .mask       (mask),
  .fast_route (fast_route),
  .norm_id    (norm_id),
  .norm_any   (norm_any),
  .fast_id    (fast_id),
  .fast_any   (fast_any),
  .done       (done)
);

// File: tb/irq_winner_pick_test.sv
module irq_winner_pick_test;
  localparam int PERIOD = 10;
  localparam int NB     = 3;
  localparam int PW     = 6;
  localparam int LINES  = NB * 32;
  localparam int IDW    = 7;
  localparam int NV     = 8;

  // two active lines per vector: A and B; B optionally masked
  localparam int LA [NV] = '{5, 10, 0, 95, 20, 50, 3, 31};
  localparam int PA [NV] = '{3, 4, 0, 2, 7, 0, 63, 10};
  localparam int FA [NV] = '{0, 0, 0, 1, 0, 1, 0, 0};
  localparam int LB [NV] = '{70, 40, 1, 33, 21, 60, 2, 32};
  localparam int PB [NV] = '{1, 4, 5, 2, 1, 9, 63, 10};
  localparam int FB [NV] = '{0, 0, 1, 1, 0, 0, 0, 0};
  localparam int MB [NV] = '{0, 0, 0, 0, 1, 0, 0, 0};
  localparam int EN [NV] = '{70, 40, 0, 0, 20, 60, 3, 32};
  localparam int EA [NV] = '{1, 1, 1, 0, 1, 1, 1, 1};
  localparam int EF [NV] = '{0, 0, 1, 95, 0, 50, 0, 0};
  localparam int EB [NV] = '{0, 0, 1, 1, 0, 1, 0, 0};
  localparam string TAG [NV] = '{"R2 R4", "R3", "R6 R9", "R3 R4 R5", "R1",
                                 "R1 R9", "R2 R3", "R4"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [LINES-1:0] pending = '0, mask = '0, fast_route = '0;
  logic [LINES*PW-1:0] prio_flat = '1;
  logic [IDW-1:0] norm_id, fast_id;
  logic norm_any, fast_any, done;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_winner_pick #(.NUM_BANKS(NB), .PRIO_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .pending(pending), .mask(mask),
    .fast_route(fast_route), .prio_flat(prio_flat), .norm_id(norm_id),
    .norm_any(norm_any), .fast_id(fast_id), .fast_any(fast_any), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    pending = '0; mask = '0; fast_route = '0; prio_flat = '1;
  endtask

  task automatic put_line(input int ln, input int p, input int f, input int m);
    pending[ln] = 1'b1;
    mask[ln] = m[0];
    fast_route[ln] = f[0];
    prio_flat[ln*PW +: PW] = PW'(p);
  endtask

  // strobe at a falling edge; results valid after the next falling edge
  task automatic resolve();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 norm_id", int'(norm_id), 0);
    check("R8 norm_any", int'(norm_any), 0);
    check("R8 fast_any", int'(fast_any), 0);
    check("R8 done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      clear_inputs();
      put_line(LA[v], PA[v], FA[v], 0);
      put_line(LB[v], PB[v], FB[v], MB[v]);
      resolve();
      check({TAG[v], " done"}, int'(done), 1);
      check({TAG[v], " norm_id"}, int'(norm_id), EN[v]);
      check({TAG[v], " norm_any"}, int'(norm_any), EA[v]);
      check({TAG[v], " fast_id"}, int'(fast_id), EF[v]);
      check({TAG[v], " fast_any"}, int'(fast_any), EB[v]);
      @(negedge clk);
      check({TAG[v], " done one cycle R7"}, int'(done), 0);
    end

    // R7: inputs change without a strobe, outputs hold (last winner 32)
    clear_inputs();
    put_line(7, 0, 0, 0);
    put_line(8, 0, 1, 0);
    repeat (3) @(negedge clk);
    check("R7 hold norm_id", int'(norm_id), 32);
    check("R7 hold fast_any", int'(fast_any), 0);
    check("R7 no done", int'(done), 0);

    // R1: every pending line masked leaves both classes empty (R5)
    mask = '1;
    resolve();
    check("R1 masked norm_any", int'(norm_any), 0);
    check("R5 masked norm_id", int'(norm_id), 0);
    check("R1 masked fast_any", int'(fast_any), 0);

    // R6: a real winner at line 0 carries the any flag
    clear_inputs();
    put_line(0, 12, 1, 0);
    resolve();
    check("R6 fast line0 id", int'(fast_id), 0);
    check("R6 fast line0 any", int'(fast_any), 1);
    check("R5 norm empty", int'(norm_any), 0);

    // R2: many candidates, lowest value wins regardless of position
    clear_inputs();
    for (int i = 0; i < LINES; i++) put_line(i, 40 + (i % 20), 0, 0);
    put_line(47, 9, 0, 0);
    put_line(48, 9, 1, 0);
    resolve();
    check("R2 many norm_id", int'(norm_id), 47);
    check("R9 many fast_id", int'(fast_id), 48);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule